// File: doc/BRIEF.md
# Programmable Scan Signature Register

This block folds the serial bit stream that comes back from a scan chain into a 32-bit signature. The signature register is a Galois-type linear feedback shift register: the bit leaving the top stage is combined with the incoming scan bit, and the result is fed back into every stage whose tap bit is set in a writable polynomial register. Software picks the polynomial, so one block can match the compression polynomial used by a test program.

A 16-bit processor bus reaches five registers. The polynomial register sits at address 07h. The starting value is written as two 16-bit halves, low at 08h and high at 09h. The signature is read as two halves, low at 0Ah and high at 0Bh. The sequencer pulses `seed_load` when a vector starts, which copies the held starting value into the signature register. After that, each clock with `shift_en` high folds in one scan bit. The signature halves always show the live register value.

Top module: `sig_lfsr`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the polynomial, both start-value halves and the signature are all zero.
- R2: A bus write to address 07h stores `bus_wdata` as the tap polynomial. From the next cycle, a read of 07h returns it.
- R3: Bus writes to 08h store the low start-value half and writes to 09h store the high half. Each half reads back at its own address. Neither write changes the signature.
- R4: A clock edge with `seed_load` high sets the signature to {half at 09h, half at 08h}, using the halves held before that edge.
- R5: A clock edge with `shift_en` high and `seed_load` low computes f = sig[31] XOR `scan_in`. Then, for every stage i from 0 to 31, new sig[i] = old sig[i-1] XOR (f AND tap[i]), where old sig[-1] is 0 and tap[i] is 0 for i of 16 and above.
- R6: On an edge with both `seed_load` and `shift_en` low, the signature is unchanged.
- R7: When `seed_load` and `shift_en` are high together, the load wins and no shift step is applied.
- R8: A read of 0Ah returns sig[15:0] and a read of 0Bh returns sig[31:16] in the same cycle, with no extra delay.
- R9: Bus writes to 0Ah, 0Bh or any unmapped address change no register. Reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 5 | Register address |
| bus_we | input | 1 | Write strobe for `bus_wdata` into `bus_addr` |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| seed_load | input | 1 | Copy the start value into the signature |
| shift_en | input | 1 | Fold one scan bit in on this edge |
| scan_in | input | 1 | Serial scan input bit |

## Verification
The hardest case to reach is an edge where a start-value half is rewritten at the same moment that `seed_load` fires, while `shift_en` is also high. On that edge the load must take the old halves and must override the shift step. The stimulus drives this triple collision on purpose. It then reads both signature halves on the next cycles.

Long shift runs use random scan bits, under an all-ones polynomial, a sparse one and a zero one. Each run reads the halves alternately, so every feedback path is compared against the bench model on every clock.

// File: rtl/sig_lfsr_pkg.sv
package sig_lfsr_pkg;

    localparam int unsigned ADDR_W = 5;

    localparam logic [ADDR_W-1:0] ADDR_TAPS    = 5'h07;
    localparam logic [ADDR_W-1:0] ADDR_SEED_LO = 5'h08;
    localparam logic [ADDR_W-1:0] ADDR_SEED_HI = 5'h09;
    localparam logic [ADDR_W-1:0] ADDR_SIG_LO  = 5'h0A;
    localparam logic [ADDR_W-1:0] ADDR_SIG_HI  = 5'h0B;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TAPS,
        SEL_SEED_LO,
        SEL_SEED_HI,
        SEL_SIG_LO,
        SEL_SIG_HI
    } reg_sel_e;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_LOAD,
        OP_STEP
    } sig_op_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        unique case (a)
            ADDR_TAPS:    s = SEL_TAPS;
            ADDR_SEED_LO: s = SEL_SEED_LO;
            ADDR_SEED_HI: s = SEL_SEED_HI;
            ADDR_SIG_LO:  s = SEL_SIG_LO;
            ADDR_SIG_HI:  s = SEL_SIG_HI;
            default:      s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic sig_op_e pick_op(input logic load, input logic step);
        sig_op_e o;
        if (load)      o = OP_LOAD;
        else if (step) o = OP_STEP;
        else           o = OP_HOLD;
        return o;
    endfunction

endpackage

// File: rtl/sig_lfsr_regfile.sv
module sig_lfsr_regfile
    import sig_lfsr_pkg::*;
#(
    parameter int unsigned BUS_W = 16,
    parameter int unsigned TAP_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  reg_sel_e         sel,
    input  logic [BUS_W-1:0] wdata,
    output logic [TAP_W-1:0] taps_q,
    output logic [BUS_W-1:0] seed_lo_q,
    output logic [BUS_W-1:0] seed_hi_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            taps_q    <= '0;
            seed_lo_q <= '0;
            seed_hi_q <= '0;
        end else if (we) begin
            case (sel)
                SEL_TAPS:    taps_q    <= wdata[TAP_W-1:0];
                SEL_SEED_LO: seed_lo_q <= wdata;
                SEL_SEED_HI: seed_hi_q <= wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sig_lfsr_shift.sv
module sig_lfsr_shift
    import sig_lfsr_pkg::*;
#(
    parameter int unsigned SIG_W = 32,
    parameter int unsigned TAP_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  sig_op_e          op,
    input  logic             scan_in,
    input  logic [TAP_W-1:0] taps,
    input  logic [SIG_W-1:0] seed,
    output logic [SIG_W-1:0] sig_q
);

    logic             fb;
    logic [SIG_W-1:0] step_v;

    assign fb = sig_q[SIG_W-1] ^ scan_in;

    for (genvar i = 0; i < SIG_W; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign step_v[i] = fb & taps[i];
        end else if (i < TAP_W) begin : g_tap
            assign step_v[i] = sig_q[i-1] ^ (fb & taps[i]);
        end else begin : g_plain
            assign step_v[i] = sig_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sig_q <= '0;
        end else begin
            case (op)
                OP_LOAD: sig_q <= seed;
                OP_STEP: sig_q <= step_v;
                default: sig_q <= sig_q;
            endcase
        end
    end

endmodule

// File: rtl/sig_lfsr_rdmux.sv
module sig_lfsr_rdmux
    import sig_lfsr_pkg::*;
#(
    parameter int unsigned BUS_W = 16,
    parameter int unsigned TAP_W = 16,
    localparam int unsigned SIG_W = 2 * BUS_W
) (
    input  reg_sel_e         sel,
    input  logic [TAP_W-1:0] taps,
    input  logic [BUS_W-1:0] seed_lo,
    input  logic [BUS_W-1:0] seed_hi,
    input  logic [SIG_W-1:0] sig,
    output logic [BUS_W-1:0] rdata
);

    always_comb begin
        case (sel)
            SEL_TAPS:    rdata = BUS_W'(taps);
            SEL_SEED_LO: rdata = seed_lo;
            SEL_SEED_HI: rdata = seed_hi;
            SEL_SIG_LO:  rdata = sig[BUS_W-1:0];
            SEL_SIG_HI:  rdata = sig[SIG_W-1:BUS_W];
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/sig_lfsr.sv
module sig_lfsr
    import sig_lfsr_pkg::*;
#(
    parameter int unsigned BUS_W = 16,
    parameter int unsigned TAP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              seed_load,
    input  logic              shift_en,
    input  logic              scan_in
);

    localparam int unsigned SIG_W = 2 * BUS_W;

    reg_sel_e         sel;
    sig_op_e          op;
    logic [TAP_W-1:0] taps_q;
    logic [BUS_W-1:0] seed_lo_q;
    logic [BUS_W-1:0] seed_hi_q;
    logic [SIG_W-1:0] seed_flat;
    logic [SIG_W-1:0] sig_q;

    assign sel       = decode_addr(bus_addr);
    assign op        = pick_op(seed_load, shift_en);
    assign seed_flat = {seed_hi_q, seed_lo_q};

    sig_lfsr_regfile #(.BUS_W(BUS_W), .TAP_W(TAP_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (bus_we),
        .sel       (sel),
        .wdata     (bus_wdata),
        .taps_q    (taps_q),
        .seed_lo_q (seed_lo_q),
        .seed_hi_q (seed_hi_q)
    );

    sig_lfsr_shift #(.SIG_W(SIG_W), .TAP_W(TAP_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .scan_in (scan_in),
        .taps    (taps_q),
        .seed    (seed_flat),
        .sig_q   (sig_q)
    );

    sig_lfsr_rdmux #(.BUS_W(BUS_W), .TAP_W(TAP_W)) u_rd (
        .sel     (sel),
        .taps    (taps_q),
        .seed_lo (seed_lo_q),
        .seed_hi (seed_hi_q),
        .sig     (sig_q),
        .rdata   (bus_rdata)
    );

endmodule

// File: rtl/sig_lfsr_chk.sv
module sig_lfsr_chk
    import sig_lfsr_pkg::*;
#(
    parameter int unsigned BUS_W = 16,
    parameter int unsigned TAP_W = 16,
    localparam int unsigned SIG_W = 2 * BUS_W
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              seed_load,
    input logic              shift_en,
    input logic              scan_in,
    input logic [SIG_W-1:0]  seed_flat,
    input logic [SIG_W-1:0]  sig_q
);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> sig_q == '0);                                          // R1

    AST_LOAD_SEED: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> sig_q == $past(seed_flat));                             // R4

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        (seed_load && shift_en) |=> sig_q == $past(seed_flat));               // R7

    AST_STEP_LSB: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !seed_load) |=> sig_q[SIG_W-1:TAP_W] == $past(sig_q[SIG_W-2:TAP_W-1])); // R5

    AST_STEP_FB: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !seed_load && (sig_q[SIG_W-1] == scan_in)) |=>
            sig_q == {$past(sig_q[SIG_W-2:0]), 1'b0});                        // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!seed_load && !shift_en) |=> $stable(sig_q));                        // R6

    AST_READ_LO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_SIG_LO) |-> bus_rdata == sig_q[BUS_W-1:0]);         // R8

    AST_READ_HI: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_SIG_HI) |-> bus_rdata == sig_q[SIG_W-1:BUS_W]);     // R8

endmodule

bind sig_lfsr sig_lfsr_chk #(.BUS_W(BUS_W), .TAP_W(TAP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .seed_load (seed_load),
    .shift_en  (shift_en),
    .scan_in   (scan_in),
    .seed_flat (seed_flat),
    .sig_q     (sig_q)
);

// File: tb/sig_lfsr_tb_top.sv
module sig_lfsr_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = 5'h0A;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        seed_load = 1'b0;
    logic        shift_en = 1'b0;
    logic        scan_in = 1'b0;

    int compared = 0;
    int mismatched = 0;
    string cur_req = "R1";

    // reference state
    logic [31:0] m_sig = '0;
    logic [15:0] m_taps = '0;
    logic [15:0] m_slo = '0;
    logic [15:0] m_shi = '0;

    always #4 clk = ~clk;

    sig_lfsr dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .seed_load (seed_load),
        .shift_en  (shift_en),
        .scan_in   (scan_in)
    );

    always @(posedge clk) begin
        logic [31:0] nsig;
        logic        f;
        if (rst) begin
            m_sig = '0; m_taps = '0; m_slo = '0; m_shi = '0;
        end else begin
            nsig = m_sig;
            if (seed_load) begin
                nsig = {m_shi, m_slo};
            end else if (shift_en) begin
                f = m_sig[31] ^ scan_in;
                nsig = m_sig << 1;
                if (f) nsig = nsig ^ {16'h0000, m_taps};
            end
            m_sig = nsig;
            if (bus_we) begin
                if (bus_addr == 5'h07) m_taps = bus_wdata;
                if (bus_addr == 5'h08) m_slo = bus_wdata;
                if (bus_addr == 5'h09) m_shi = bus_wdata;
            end
        end
    end

    function automatic logic [15:0] model_read(input logic [4:0] a);
        case (a)
            5'h07:   return m_taps;
            5'h08:   return m_slo;
            5'h09:   return m_shi;
            5'h0A:   return m_sig[15:0];
            5'h0B:   return m_sig[31:16];
            default: return 16'h0000;
        endcase
    endfunction

    task automatic cyc(input logic [4:0] a, input logic we, input logic [15:0] wd,
                       input logic ld, input logic sh, input logic si);
        logic [15:0] exp_v;
        bus_addr = a; bus_we = we; bus_wdata = wd;
        seed_load = ld; shift_en = sh; scan_in = si;
        @(negedge clk);
        exp_v = model_read(bus_addr);
        compared++;
        if (bus_rdata !== exp_v) begin
            mismatched++;
            $display("FAIL %s addr=%h actual=%h expected=%h", cur_req, bus_addr, bus_rdata, exp_v);
        end
    endtask

    task automatic rd(input logic [4:0] a);
        cyc(a, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        cyc(a, 1'b1, d, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic shift_run(input int n);
        for (int k = 0; k < n; k++)
            cyc((k % 2 == 0) ? 5'h0A : 5'h0B, 1'b0, 16'h0, 1'b0, 1'b1, 1'($urandom));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state on all addresses
        cur_req = "R1";
        rst = 1'b1;
        for (int a = 7; a <= 11; a++) cyc(5'(a), 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        for (int a = 7; a <= 11; a++) rd(5'(a));

        cur_req = "R2";
        wr(5'h07, 16'h8057);
        rd(5'h07);
        wr(5'h07, 16'hFFFF);
        rd(5'h07);

        cur_req = "R3";
        wr(5'h08, 16'h1234);
        wr(5'h09, 16'hC0DE);
        rd(5'h08); rd(5'h09); rd(5'h0A); rd(5'h0B);

        cur_req = "R4";
        cyc(5'h0A, 1'b0, 16'h0, 1'b1, 1'b0, 1'b0);
        rd(5'h0B);

        cur_req = "R5";
        shift_run(48);
        wr(5'h07, 16'h0001);
        cyc(5'h0A, 1'b0, 16'h0, 1'b1, 1'b0, 1'b0);
        shift_run(40);
        wr(5'h07, 16'h0000);
        shift_run(40);
        wr(5'h07, 16'hA5C3);
        shift_run(64);

        cur_req = "R6";
        for (int k = 0; k < 6; k++) cyc((k % 2 == 0) ? 5'h0A : 5'h0B, 1'b0, 16'h0, 1'b0, 1'b0, 1'($urandom));

        cur_req = "R7";
        cyc(5'h09, 1'b1, 16'h7E81, 1'b1, 1'b1, 1'b1);
        rd(5'h0A); rd(5'h0B);
        cyc(5'h0B, 1'b0, 16'h0, 1'b1, 1'b1, 1'b1);
        rd(5'h0A);

        cur_req = "R8";
        shift_run(20);

        cur_req = "R9";
        wr(5'h0A, 16'hDEAD); rd(5'h0A);
        wr(5'h0B, 16'hBEEF); rd(5'h0B);
        wr(5'h1F, 16'h5555); rd(5'h1F);
        wr(5'h00, 16'hAAAA); rd(5'h00);
        rd(5'h07); rd(5'h08); rd(5'h09);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule